// File: doc/BRIEF.md
# Output-Coded Turn Signal Sequencer

This block sequences six tail lamps, three per side, for turn indication and hazard flashing. Its state register is the lamp vector. Each state code is chosen to equal the lamp pattern for that state, so the lamps come straight from the flip-flops. No decoding logic sits between the register and the outputs, and no input reaches an output without first passing a clock edge.

A turn request lights the lamps on its side one at a time, starting with the lamp nearest the vehicle centre and spreading outward. After the third step the machine goes dark for one step, then starts again if the request is still held, which produces a blink. A hazard request, or a left and a right request held together, flashes all six lamps together.

The machine advances only on cycles where `step_en` is high, so a blink-rate prescaler can drive that input. A turn sequence that has started runs to its end whatever the turn inputs do, but a hazard request cuts it short. Codes outside the eight legal patterns can only appear after an upset, and they return to dark on the next clock.

Top module: `turn_lamp_seq`

## Requirements
- R1: `lamps[5:3]` are the left lamps, with `lamps[3]` the innermost and `lamps[5]` the outermost. `lamps[2:0]` are the right lamps, with `lamps[2]` the innermost and `lamps[0]` the outermost. A lamp is lit when its bit is 1. The outputs change only just after a rising clock edge, never as a direct result of an input change.
- R2: While `rst` is high at a rising edge, the lamps become 000000 at that edge.
- R3: From dark (000000), with only `turn_left` high, successive steps give 001000, 011000, 111000 and then 000000.
- R4: From dark, with only `turn_right` high, successive steps give 000100, 000110, 000111 and then 000000.
- R5: From dark, with `hazard` high, or with `turn_left` and `turn_right` both high, the next step gives 111111 and the step after it gives 000000. `hazard` outranks either turn request.
- R6: From dark, a request that is still held at the step after a sequence ends restarts the sequence. With no request held, the lamps stay dark.
- R7: Once a turn sequence has started, it runs to its third step even if its own request drops or the opposite turn request rises.
- R8: During a turn sequence, a step with `hazard` high returns the lamps to 000000.
- R9: On a clock edge with `step_en` low, the lamps keep their value.
- R10: Only the eight legal codes ever appear on `lamps`: dark, all lit, and the three steps of each side. Any other code returns to dark on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance enable; the state moves only on cycles where this is high |
| turn_left | input | 1 | Left turn request |
| turn_right | input | 1 | Right turn request |
| hazard | input | 1 | Hazard flash request |
| lamps | output | 6 | Lamp pattern, taken directly from the state flip-flops |

## Verification
The assertions check, on every cycle, the properties that depend only on the current cycle and the one before it:
- the lamps always hold a legal code;
- the lamps hold still when `step_en` is low;
- all-lit is always followed by dark;
- a turn step without `hazard` adds exactly one lamp;
- `hazard` aborts a running sequence;
- reset clears the lamps.

Only the bench's scenarios can show the following:
- the exact order of each side's steps;
- the blink restart after the dark step;
- the priority of a left-plus-right request over a single turn;
- that a running sequence ignores turn inputs that change partway through;
- that an input change between edges leaves the lamps untouched.

// File: rtl/turn_lamp_pkg.sv
package turn_lamp_pkg;

    // Decoded request seen from the dark state, in priority order.
    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_FLASH = 2'd1,
        REQ_LEFT  = 2'd2,
        REQ_RIGHT = 2'd3
    } lamp_req_e;

endpackage

// File: rtl/lamp_req_arbiter.sv
module lamp_req_arbiter
    import turn_lamp_pkg::*;
(
    input  logic      hazard_i,
    input  logic      left_i,
    input  logic      right_i,
    output lamp_req_e req_o
);

    // A hazard request, or both turns together, wins over a single turn.
    always_comb begin
        if (hazard_i || (left_i && right_i)) begin
            req_o = REQ_FLASH;
        end else if (left_i) begin
            req_o = REQ_LEFT;
        end else if (right_i) begin
            req_o = REQ_RIGHT;
        end else begin
            req_o = REQ_NONE;
        end
    end

endmodule

// File: rtl/lamp_side_fill.sv
// Step logic for one side of lamps. Internally the side is viewed with its
// innermost lamp at bit 0; GROW_UP selects whether that view matches the
// physical bit order or is its mirror image.
module lamp_side_fill #(
    parameter int SIDE_W  = 3,
    parameter bit GROW_UP = 1'b1
) (
    input  logic [SIDE_W-1:0] fill_i,
    output logic [SIDE_W-1:0] start_o,
    output logic [SIDE_W-1:0] next_o,
    output logic              dark_o,
    output logic              legal_o,
    output logic              full_o
);

    localparam logic [SIDE_W-1:0] INNER_C = SIDE_W'(1);

    logic [SIDE_W-1:0] canon;
    logic [SIDE_W-1:0] next_c;
    logic [SIDE_W-1:0] start_c;

    for (genvar b = 0; b < SIDE_W; b++) begin : g_map
        if (GROW_UP) begin : g_keep
            assign canon[b]   = fill_i[b];
            assign next_o[b]  = next_c[b];
            assign start_o[b] = start_c[b];
        end else begin : g_flip
            assign canon[b]              = fill_i[SIDE_W-1-b];
            assign next_o[SIDE_W-1-b]    = next_c[b];
            assign start_o[SIDE_W-1-b]   = start_c[b];
        end
    end

    always_comb begin
        start_c = INNER_C;
        next_c  = (canon << 1) | INNER_C;
        dark_o  = (canon == '0);
        full_o  = &canon;
        // Legal run: a nonzero block of ones anchored at the inner lamp.
        legal_o = !dark_o && ((canon & (canon + INNER_C)) == '0);
    end

endmodule

// File: rtl/turn_lamp_seq.sv
module turn_lamp_seq
    import turn_lamp_pkg::*;
#(
    parameter int SIDE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    input  logic                  turn_left,
    input  logic                  turn_right,
    input  logic                  hazard,
    output logic [2*SIDE_W-1:0]   lamps
);

    localparam int LAMP_W  = 2 * SIDE_W;
    localparam int N_SIDES = 2;
    localparam int SIDE_L  = 0;
    localparam int SIDE_R  = 1;

    typedef struct packed {
        logic [SIDE_W-1:0] lft;
        logic [SIDE_W-1:0] rgt;
    } lamp_state_t;

    lamp_state_t st_d, st_q;

    lamp_req_e                      req;
    logic [N_SIDES-1:0][SIDE_W-1:0] side_cur;
    logic [N_SIDES-1:0][SIDE_W-1:0] side_start;
    logic [N_SIDES-1:0][SIDE_W-1:0] side_next;
    logic [N_SIDES-1:0]             side_dark;
    logic [N_SIDES-1:0]             side_legal;
    logic [N_SIDES-1:0]             side_full;

    logic is_idle, is_flash, run_left, run_right, code_ok;

    lamp_req_arbiter u_arb (
        .hazard_i (hazard),
        .left_i   (turn_left),
        .right_i  (turn_right),
        .req_o    (req)
    );

    assign side_cur[SIDE_L] = st_q.lft;
    assign side_cur[SIDE_R] = st_q.rgt;

    // Left side grows toward the high bit, right side toward the low bit.
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        lamp_side_fill #(
            .SIDE_W  (SIDE_W),
            .GROW_UP (s == SIDE_L)
        ) u_fill (
            .fill_i  (side_cur[s]),
            .start_o (side_start[s]),
            .next_o  (side_next[s]),
            .dark_o  (side_dark[s]),
            .legal_o (side_legal[s]),
            .full_o  (side_full[s])
        );
    end

    always_comb begin
        is_idle   = side_dark[SIDE_L] && side_dark[SIDE_R];
        is_flash  = side_full[SIDE_L] && side_full[SIDE_R];
        run_left  = side_legal[SIDE_L] && side_dark[SIDE_R];
        run_right = side_dark[SIDE_L] && side_legal[SIDE_R];
        code_ok   = is_idle || is_flash || run_left || run_right;
    end

    always_comb begin
        st_d = st_q;
        if (!code_ok) begin
            st_d = '0;
        end else if (step_en) begin
            if (is_idle) begin
                case (req)
                    REQ_FLASH: st_d = '1;
                    REQ_LEFT:  st_d.lft = side_start[SIDE_L];
                    REQ_RIGHT: st_d.rgt = side_start[SIDE_R];
                    default:   st_d = '0;
                endcase
            end else if (is_flash) begin
                st_d = '0;
            end else if (run_left) begin
                st_d.rgt = '0;
                st_d.lft = (hazard || side_full[SIDE_L]) ? '0 : side_next[SIDE_L];
            end else begin
                st_d.lft = '0;
                st_d.rgt = (hazard || side_full[SIDE_R]) ? '0 : side_next[SIDE_R];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lamps = st_q;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    AST_RESET_DARK: assert property (@(posedge clk) rst |=> (lamps == '0)); // R2

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        (lamps == '0) || (lamps == '1) ||
        ((lamps[SIDE_W-1:0] == '0) &&
         (lamps[LAMP_W-1:SIDE_W] ==
          SIDE_W'((SIDE_W'(1) << $countones(lamps)) - SIDE_W'(1)))) ||
        ((lamps[LAMP_W-1:SIDE_W] == '0) &&
         (lamps[SIDE_W-1:0] == ~({SIDE_W{1'b1}} >> $countones(lamps))))); // R10

    AST_FLASH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (step_en && lamps == '1) |=> (lamps == '0)); // R5

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(lamps)); // R9

    AST_TURN_GROWS: assert property (@(posedge clk) disable iff (rst)
        (step_en && !hazard && lamps != '0 &&
         (lamps[SIDE_W-1:0] == '0 || lamps[LAMP_W-1:SIDE_W] == '0) &&
         !(&lamps[SIDE_W-1:0]) && !(&lamps[LAMP_W-1:SIDE_W]))
        |=> ($countones(lamps) == $past($countones(lamps)) + 1)); // R7

    AST_HAZ_ABORT: assert property (@(posedge clk) disable iff (rst)
        (step_en && hazard && lamps != '0 && lamps != '1) |=> (lamps == '0)); // R8

endmodule

// File: tb/turn_lamp_seq_tb_top.sv
module turn_lamp_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b1;
    logic       turn_left = 1'b0;
    logic       turn_right = 1'b0;
    logic       hazard = 1'b0;
    logic [5:0] lamps;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_lamps = 6'b000000;

    always #(CLK_PERIOD/2) clk = ~clk;

    turn_lamp_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .turn_left  (turn_left),
        .turn_right (turn_right),
        .hazard     (hazard),
        .lamps      (lamps)
    );

    // Next pattern computed from the requirements.
    function automatic logic [5:0] model(input logic [5:0] s, input logic l,
                                         input logic r, input logic h, input logic en);
        if (!en) return s;
        case (s)
            6'b000000: begin
                if (h || (l && r)) return 6'b111111;
                if (l)             return 6'b001000;
                if (r)             return 6'b000100;
                return 6'b000000;
            end
            6'b001000: return h ? 6'b000000 : 6'b011000;
            6'b011000: return h ? 6'b000000 : 6'b111000;
            6'b000100: return h ? 6'b000000 : 6'b000110;
            6'b000110: return h ? 6'b000000 : 6'b000111;
            default:   return 6'b000000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: lamps=%b expected=%b", tag, got, want);
        end
    endtask

    task automatic check_legal();
        checks++;
        if (!(lamps inside {6'b000000, 6'b111111, 6'b001000, 6'b011000, 6'b111000,
                            6'b000100, 6'b000110, 6'b000111})) begin
            errors++;
            $display("FAIL R10: lamps=%b expected=one of the legal codes", lamps);
        end
    endtask

    // Apply inputs just after an edge, take one edge, then check the result.
    task automatic cyc(input string tag, input logic l, input logic r,
                       input logic h, input logic en);
        turn_left = l; turn_right = r; hazard = h; step_en = en;
        @(posedge clk); #1;
        exp_lamps = model(exp_lamps, l, r, h, en);
        check(tag, lamps, exp_lamps);
        check_legal();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        exp_lamps = 6'b000000;
        check("R2 reset", lamps, 6'b000000);
        rst = 1'b0;
    endtask

    task automatic t_left();
        cyc("R3 left step1", 1, 0, 0, 1);
        check("R3 left inner lamp", lamps, 6'b001000);
        cyc("R3 left step2", 1, 0, 0, 1);
        cyc("R3 left step3", 1, 0, 0, 1);
        check("R3 left full", lamps, 6'b111000);
        cyc("R3 left dark", 0, 0, 0, 1);
        check("R3 left end", lamps, 6'b000000);
    endtask

    task automatic t_right();
        cyc("R4 right step1", 0, 1, 0, 1);
        check("R4 right inner lamp", lamps, 6'b000100);
        cyc("R4 right step2", 0, 1, 0, 1);
        cyc("R4 right step3", 0, 1, 0, 1);
        check("R4 right full", lamps, 6'b000111);
        cyc("R4 right dark", 0, 0, 0, 1);
    endtask

    task automatic t_flash();
        cyc("R5 hazard on", 0, 0, 1, 1);
        check("R5 hazard all lit", lamps, 6'b111111);
        cyc("R5 hazard off", 0, 0, 1, 1);
        cyc("R5 hazard repeat", 1, 0, 1, 1);
        check("R5 hazard beats left", lamps, 6'b111111);
        cyc("R5 dark", 1, 1, 0, 1);
        cyc("R5 both turns flash", 1, 1, 0, 1);
        check("R5 both turns", lamps, 6'b111111);
        cyc("R5 both dark", 0, 0, 0, 1);
    endtask

    task automatic t_blink();
        for (int k = 0; k < 4; k++) cyc("R6 left blink", 1, 0, 0, 1);
        check("R6 dark between", lamps, 6'b000000);
        cyc("R6 restart", 1, 0, 0, 1);
        check("R6 restart step1", lamps, 6'b001000);
        for (int k = 0; k < 3; k++) cyc("R6 finish", 0, 0, 0, 1);
        cyc("R6 stays dark", 0, 0, 0, 1);
        check("R6 idle without request", lamps, 6'b000000);
    endtask

    task automatic t_committed();
        cyc("R7 start right", 0, 1, 0, 1);
        cyc("R7 right held by nothing", 0, 0, 0, 1);
        check("R7 right continues", lamps, 6'b000110);
        cyc("R7 left raised", 1, 0, 0, 1);
        check("R7 ignores left", lamps, 6'b000111);
        cyc("R7 end", 0, 0, 0, 1);
    endtask

    task automatic t_abort();
        cyc("R8 start left", 1, 0, 0, 1);
        cyc("R8 left2", 1, 0, 0, 1);
        cyc("R8 hazard abort", 1, 0, 1, 1);
        check("R8 aborted", lamps, 6'b000000);
        cyc("R8 start right", 0, 1, 0, 1);
        cyc("R8 hazard abort right", 0, 0, 1, 1);
        check("R8 aborted right", lamps, 6'b000000);
    endtask

    task automatic t_hold();
        cyc("R9 start left", 1, 0, 0, 1);
        cyc("R9 left2", 1, 0, 0, 1);
        for (int k = 0; k < 3; k++) cyc("R9 hold", 0, 1, 1, 0);
        check("R9 held", lamps, 6'b011000);
        cyc("R9 resume", 0, 0, 0, 1);
        check("R9 resumed", lamps, 6'b111000);
        cyc("R9 dark", 0, 0, 0, 1);
        cyc("R9 idle hold", 1, 0, 0, 0);
        check("R9 idle held", lamps, 6'b000000);
    endtask

    task automatic t_no_comb_path();
        cyc("R1 start left", 1, 0, 0, 1);
        hazard = 1'b1; turn_right = 1'b1;
        #2;
        check("R1 no change between edges", lamps, 6'b001000);
        turn_left = 1'b0;
        #1;
        check("R1 still registered", lamps, 6'b001000);
        cyc("R1 hazard at edge", 0, 0, 1, 1);
        check("R1 bit map dark", lamps, 6'b000000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_left();
        t_right();
        t_flash();
        t_blink();
        t_committed();
        t_abort();
        t_hold();
        t_no_comb_path();
        cyc("R2 pre-reset", 1, 0, 0, 1);
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule